// File: doc/BRIEF.md
# Quadrature Decoder with Edge-Period Capture

This block turns the two phase-shifted channels of an incremental encoder into a signed position count. It also records two things about the last edge it counted: its direction, and the number of clock ticks since the edge before it. Software reads the count and the interval and derives speed on its own side. The decoder only supplies raw integers. Unit scaling, filtering and floating-point work stay outside it. The intended system clock is 40 MHz, and that clock is also the time base for the interval.

Each channel passes through a flop synchroniser. Every sampled level is then compared with the one before it, so all four edges of an encoder cycle are counted. A step where both channels change at once cannot be decoded. Such a step is flagged and is not counted. If no edge arrives within a programmable number of ticks, the block reports a stall and forces the interval output to its maximum, so software sees a very low speed instead of an old value.

Top module: `qdec_period_top`

## Requirements
- R1: All four edges are counted (x4 decoding). When channel A leads, the levels {encA,encB} step through 00, 10, 11, 01, 00 and each step adds one to `position`. The reverse order subtracts one per step.
- R2: A valid edge on the inputs reaches `position` and `dirUp` at the third rising clock edge after the input changes: two synchroniser stages plus the edge register. `position` never moves by more than one per cycle unless a clear occurs.
- R3: `dirUp` is 1 after a counted increment and 0 after a counted decrement. It updates in the same cycle as `position` and holds between edges.
- R4: A sample in which both channels changed leaves `position`, `dirUp` and `period` unchanged. It sets `phaseError`, which stays 1 until reset.
- R5: A one-cycle `clearCount` makes `position` zero on the next cycle and leaves `period` and `dirUp` as they are. If a counted edge lands in the same cycle, the clear wins for `position`, and direction and period still take the edge's values.
- R6: `period` holds the number of clock ticks between the two most recent counted edges. A direction reversal does not break this: the interval is still measured from the previous edge.
- R7: With `stallLimit` non-zero, once the ticks since the last counted edge reach `stallLimit`, `stalled` goes to 1 and `period` reads all ones. The next counted edge clears `stalled` and loads the measured interval. A `stallLimit` of zero disables stall detection.
- R8: `position` is a two's-complement value that wraps. A decrement from zero gives all ones (-1).
- R9: After reset, `position`, `dirUp`, `period`, `stalled` and `phaseError` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (intended 40 MHz), also the period time base |
| rst | input | 1 | Synchronous reset, active high |
| encA | input | 1 | Raw encoder channel A, asynchronous |
| encB | input | 1 | Raw encoder channel B, asynchronous |
| clearCount | input | 1 | One-cycle strobe that zeroes the position count |
| stallLimit | input | 32 | Ticks without an edge before a stall is reported; 0 disables |
| position | output | 32 | Signed position count |
| dirUp | output | 1 | Direction of the last counted edge, 1 = increment |
| period | output | 32 | Ticks between the last two counted edges, all ones while stalled |
| stalled | output | 1 | No counted edge within `stallLimit` ticks |
| phaseError | output | 1 | Sticky flag for a sample with both channels changed |

## Verification
The bound checker watches, on every cycle, the properties that hold whatever the stimulus. `position` moves by at most one step outside a clear, and a clear always lands on zero. `phaseError` never drops once set. `period` reads all ones whenever `stalled` is high, and it holds steady when no edge or stall event occurs. A direction change or a count change without a clear implies a fresh, non-stalled edge. The bench scenarios are needed for everything that depends on the exact values. These include the decode direction for each of the four transitions, the three-cycle latency, and the tick intervals across a reversal. They also include how the decoder behaves when a clear coincides with an edge, the wrap below zero, the stall threshold and its release, and the disabled-timeout case.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // Strobes from the control to the datapath, valid for one cycle each
  typedef struct packed {
    logic step;       // a legal edge was seen this cycle
    logic up;         // direction of that edge, 1 = increment
    logic illegal;    // both channels changed in one sample
    logic stallMark;  // timeout reached with no edge
    logic clear;      // zero the position count
  } qdecStrobes_t;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= rawIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int TICK_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syncA,
  input  logic              syncB,
  input  logic              clearCount,
  input  logic [TICK_W-1:0] stallLimit,
  input  logic [TICK_W-1:0] elapsed,
  output qdecStrobes_t      strobes
);

  // Edge comparison waits until the synchroniser holds real samples
  localparam int ARM_CYCLES = SYNC_STAGES + 1;
  localparam int ARM_W      = $clog2(ARM_CYCLES + 1);

  logic [ARM_W-1:0] armCnt;
  logic             armed;
  logic             prevA, prevB;
  logic             chgA, chgB;
  logic             stepNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      armCnt <= '0;
      prevA  <= 1'b0;
      prevB  <= 1'b0;
    end else begin
      prevA <= syncA;
      prevB <= syncB;
      if (!armed) armCnt <= armCnt + 1'b1;
    end
  end

  assign armed = (armCnt == ARM_W'(ARM_CYCLES));
  assign chgA  = syncA ^ prevA;
  assign chgB  = syncB ^ prevB;
  assign stepNow = armed && (chgA ^ chgB);

  always_comb begin
    strobes.step      = stepNow;
    // New A against old B gives the sense of rotation for any single edge
    strobes.up        = syncA ^ prevB;
    strobes.illegal   = armed && chgA && chgB;
    strobes.stallMark = armed && !stepNow && (stallLimit != '0) &&
                        (elapsed >= stallLimit);
    strobes.clear     = clearCount;
  end

endmodule

// File: rtl/qdec_dp.sv
module qdec_dp
  import qdec_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int TICK_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  qdecStrobes_t              strobes,
  output logic [TICK_W-1:0]         elapsed,
  output logic signed [COUNT_W-1:0] position,
  output logic                      dirUp,
  output logic [TICK_W-1:0]         period,
  output logic                      stalled,
  output logic                      phaseError
);

  logic [TICK_W-1:0] tickCount;
  logic [TICK_W-1:0] lastStamp;

  assign elapsed = tickCount - lastStamp;

  // Free-running time base
  always_ff @(posedge clk) begin
    if (rst) tickCount <= '0;
    else     tickCount <= tickCount + 1'b1;
  end

  // Position accumulator, clear has priority over a step
  always_ff @(posedge clk) begin
    if (rst)                position <= '0;
    else if (strobes.clear) position <= '0;
    else if (strobes.step)  position <= strobes.up ? position + 1'b1
                                                   : position - 1'b1;
  end

  // Edge capture: direction, timestamp and interval
  always_ff @(posedge clk) begin
    if (rst) begin
      dirUp     <= 1'b0;
      lastStamp <= '0;
      period    <= '0;
      stalled   <= 1'b0;
    end else if (strobes.step) begin
      dirUp     <= strobes.up;
      lastStamp <= tickCount;
      period    <= elapsed;
      stalled   <= 1'b0;
    end else if (strobes.stallMark) begin
      period    <= '1;
      stalled   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  phaseError <= 1'b0;
    else if (strobes.illegal) phaseError <= 1'b1;
  end

endmodule

// File: rtl/qdec_period_top.sv
module qdec_period_top
  import qdec_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int TICK_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      encA,
  input  logic                      encB,
  input  logic                      clearCount,
  input  logic [TICK_W-1:0]         stallLimit,
  output logic signed [COUNT_W-1:0] position,
  output logic                      dirUp,
  output logic [TICK_W-1:0]         period,
  output logic                      stalled,
  output logic                      phaseError
);

  logic [1:0]        syncAB;
  logic [TICK_W-1:0] elapsed;
  qdecStrobes_t      strobes;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rawIn   ({encA, encB}),
    .syncOut (syncAB)
  );

  qdec_ctrl #(.TICK_W(TICK_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .syncA      (syncAB[1]),
    .syncB      (syncAB[0]),
    .clearCount (clearCount),
    .stallLimit (stallLimit),
    .elapsed    (elapsed),
    .strobes    (strobes)
  );

  qdec_dp #(.COUNT_W(COUNT_W), .TICK_W(TICK_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .elapsed    (elapsed),
    .position   (position),
    .dirUp      (dirUp),
    .period     (period),
    .stalled    (stalled),
    .phaseError (phaseError)
  );

endmodule

// File: rtl/qdec_period_checker.sv
module qdec_period_checker #(
  parameter int COUNT_W = 32,
  parameter int TICK_W  = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      clearCount,
  input logic signed [COUNT_W-1:0] position,
  input logic                      dirUp,
  input logic [TICK_W-1:0]         period,
  input logic                      stalled,
  input logic                      phaseError
);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    !clearCount |=> ((position == $past(position)) ||
                     (position == $past(position) + 1) ||
                     (position == $past(position) - 1)));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clearCount |=> (position == '0));

  p_error_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    phaseError |=> phaseError);

  p_stall_max_r7: assert property (@(posedge clk) disable iff (rst)
    stalled |-> (period == '1));

  p_dir_with_count_r3: assert property (@(posedge clk) disable iff (rst)
    ((dirUp != $past(dirUp)) && !$past(clearCount)) |->
      (position != $past(position)));

  p_edge_unstalls_r7: assert property (@(posedge clk) disable iff (rst)
    ((position != $past(position)) && !$past(clearCount)) |-> !stalled);

  p_period_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!stalled && !$past(stalled) && !$past(clearCount) &&
     (position == $past(position))) |-> (period == $past(period)));

endmodule

bind qdec_period_top qdec_period_checker #(.COUNT_W(COUNT_W), .TICK_W(TICK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clearCount (clearCount),
  .position   (position),
  .dirUp      (dirUp),
  .period     (period),
  .stalled    (stalled),
  .phaseError (phaseError)
);

// File: tb/sim_qdec_period_top.sv
module sim_qdec_period_top;

  typedef struct {
    int          due;
    logic [31:0] pos;
    logic        dir;
    logic [31:0] per;
    logic        chkPer;
    logic        stl;
    logic        err;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        encA = 1'b0, encB = 1'b0;
  logic        clearCount = 1'b0;
  logic [31:0] stallLimit = 32'd1000;
  logic [31:0] position;
  logic        dirUp;
  logic [31:0] period;
  logic        stalled;
  logic        phaseError;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  expItem_t q[$];

  // Bench model of the expected state
  logic [31:0] expPos = '0;
  logic        expDir = 1'b0;
  logic [31:0] expPer = '0;
  logic        expErr = 1'b0;
  int          lastEdgeCyc = 0;
  bit          haveEdge = 0;

  qdec_period_top u0 (
    .clk(clk), .rst(rst), .encA(encA), .encB(encB),
    .clearCount(clearCount), .stallLimit(stallLimit),
    .position(position), .dirUp(dirUp), .period(period),
    .stalled(stalled), .phaseError(phaseError)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input bit chkPer, input bit stl, input string tag);
    expItem_t it;
    it.due = due; it.pos = expPos; it.dir = expDir;
    it.per = stl ? 32'hFFFF_FFFF : expPer;
    it.chkPer = chkPer; it.stl = stl; it.err = expErr; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations when they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      total++;
      if (position !== it.pos || dirUp !== it.dir || stalled !== it.stl ||
          phaseError !== it.err || (it.chkPer && period !== it.per)) begin
        bad++;
        $display("FAIL %s: pos=%h dir=%b per=%0d stl=%b err=%b expected pos=%h dir=%b per=%0d(chk %b) stl=%b err=%b",
                 it.tag, position, dirUp, period, stalled, phaseError,
                 it.pos, it.dir, it.per, it.chkPer, it.stl, it.err);
      end
    end
  end

  // Driver: apply new channel levels at a falling edge, then idle for gap cycles
  task automatic drive(input logic a, input logic b, input int gap,
                       input bit withClear, input string tag);
    bit chkPer;
    @(negedge clk);
    chkPer = 0;
    if ((a != encA) && (b != encB)) begin
      expErr = 1'b1;                 // R4: nothing else moves
      chkPer = haveEdge;
    end else if ((a != encA) || (b != encB)) begin
      expDir = a ^ encB;             // R1/R3: new A against old B
      expPos = withClear ? 32'd0 : (expDir ? expPos + 1 : expPos - 1);
      if (haveEdge) begin
        expPer = 32'(cyc - lastEdgeCyc);   // R6
        chkPer = 1;
      end
      lastEdgeCyc = cyc;
      haveEdge = 1;
    end
    encA = a; encB = b;
    push(cyc + 3, chkPer, 1'b0, tag);      // R2: third rising edge
    if (withClear) begin
      @(negedge clk); @(negedge clk);
      clearCount = 1'b1;                   // lands with the edge: R5
      @(negedge clk);
      clearCount = 1'b0;
      gap = gap - 3;
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulseClear(input string tag);
    @(negedge clk);
    clearCount = 1'b1;
    expPos = '0;
    push(cyc + 1, haveEdge, 1'b0, tag);
    @(negedge clk);
    clearCount = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    push(cyc + 1, 1'b1, 1'b0, "R9 reset state");
    repeat (6) @(negedge clk);

    // Forward sequence, A leads
    drive(1, 0, 4, 0, "R1 R2 up 00->10");
    drive(1, 1, 6, 0, "R1 R6 up 10->11");
    drive(0, 1, 3, 0, "R1 R3 up 11->01");
    drive(0, 0, 7, 0, "R1 R6 up 01->00");
    // Reversal, then backward sequence
    drive(0, 1, 5, 0, "R6 R3 reversal 00->01");
    drive(1, 1, 4, 0, "R1 down 01->11");
    drive(1, 0, 8, 0, "R1 down 11->10");
    drive(0, 0, 5, 0, "R1 down 10->00");
    drive(1, 0, 6, 0, "R3 reversal up 00->10");

    // Clear keeps direction and period, then wrap below zero
    pulseClear("R5 clear");
    drive(0, 0, 5, 0, "R8 wrap to -1");
    drive(0, 1, 5, 0, "R8 down to -2");

    // Clear coinciding with an edge
    drive(1, 1, 8, 1, "R5 clear wins over edge");

    // Illegal double change then recovery
    drive(0, 0, 6, 0, "R4 both channels changed");
    drive(1, 0, 6, 0, "R4 error stays set after legal edge");

    // Stall detection
    @(negedge clk);
    stallLimit = 32'd20;
    drive(1, 1, 40, 0, "R7 edge before stall");
    push(cyc + 1, 1'b1, 1'b1, "R7 stalled period max");
    @(negedge clk); @(negedge clk);
    drive(0, 1, 6, 0, "R7 edge releases stall");

    // Timeout disabled
    @(negedge clk);
    stallLimit = 32'd0;
    drive(0, 0, 80, 0, "R7 edge with limit zero");
    push(cyc + 1, 1'b1, 1'b0, "R7 no stall when limit zero");
    repeat (4) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule